// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Register Access

This block gathers up to 64 level-sensitive interrupt request lines into a single interrupt output for a parent processor or interrupt controller. Two independent per-source controls decide what gets through. An enable bit admits a source, and a mask bit blocks it. A source reaches the output only when it is enabled and not masked. Software reads the qualified state of every source from a read-only status pair. It uses that pair to find which lines need service.

The number of sources is a parameter, `NUM_SRC`, with a legal range of 2 to 64. Sources 0 to 31 sit in the low 32-bit word of each register pair, and sources 32 to 63 sit in the high word. Control flops for positions at or above `NUM_SRC` are not built, so those bits always read as zero. Driver code can therefore write all ones to the enable pair and read it back to learn how many sources exist.

All register access goes through a zero-wait-state APB slave.

Top module: `apb_irq_agg`

## Requirements
- R1: After synchronous reset, every enable and mask bit is 0, `irq_o` is 0, and `prdata` is 0.
- R2: The enable pair is read/write. The low word (sources 0..31) is at offset 0x00 and the high word (sources 32..63) is at offset 0x04. Bit k of a word controls source 32*w+k, where w is 0 for the low word and 1 for the high word.
- R3: The mask pair is read/write. The low word is at offset 0x08 and the high word is at offset 0x0C, with the same bit-to-source mapping as R2.
- R4: Enable and mask bits for sources numbered NUM_SRC or above read back as 0, even after all ones are written to them.
- R5: The status pair is read-only, with the low word at offset 0x30 and the high word at offset 0x34. Status bit i equals src[i] AND enable[i] AND NOT mask[i]. Mask 1 blocks the source and mask 0 passes it.
- R6: Status is level-following and not latched. Once a source drops, its status bit reads 0 on the next read, and reading the status does not clear it.
- R7: `irq_o` is the OR of all status bits, registered. It changes on the first rising clock edge after the qualified state changes.
- R8: `pready` is always 1 and `pslverr` is always 0. Read data is captured at the setup-phase edge and is valid throughout the access phase.
- R9: Reads of offsets other than the six listed ones return 0. Writes to those offsets change no enable or mask bit.
- R10: Writes to the status offsets 0x30 and 0x34 change no enable, mask or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_src | input | NUM_SRC | Level-sensitive interrupt request lines |
| irq_o | output | 1 | Combined interrupt to the parent |

## Verification
The timing of each result is fixed:
- A register write takes effect on the access-phase edge, so a read that starts on the next setup phase already sees the new value.
- Read data is registered at the setup-phase edge. The bench samples it on the falling edge inside the access phase.
- A status read shows the source level that was present at its setup edge.
- `irq_o` trails a change on a source or control bit by exactly one rising edge. The bench samples it once just after the change to confirm the old value still holds, and again on the next falling edge for the new value.

// File: rtl/apb_irq_pkg.sv
package apb_irq_pkg;

  localparam int REG_W = 32;
  localparam int MAX_SRC = 64;

  localparam logic [7:0] OFF_EN_LO = 8'h00;
  localparam logic [7:0] OFF_EN_HI = 8'h04;
  localparam logic [7:0] OFF_MK_LO = 8'h08;
  localparam logic [7:0] OFF_MK_HI = 8'h0C;
  localparam logic [7:0] OFF_ST_LO = 8'h30;
  localparam logic [7:0] OFF_ST_HI = 8'h34;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_LO,
    SEL_EN_HI,
    SEL_MK_LO,
    SEL_MK_HI,
    SEL_ST_LO,
    SEL_ST_HI
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [7:0] off);
    case (off)
      OFF_EN_LO: decode_off = SEL_EN_LO;
      OFF_EN_HI: decode_off = SEL_EN_HI;
      OFF_MK_LO: decode_off = SEL_MK_LO;
      OFF_MK_HI: decode_off = SEL_MK_HI;
      OFF_ST_LO: decode_off = SEL_ST_LO;
      OFF_ST_HI: decode_off = SEL_ST_HI;
      default:   decode_off = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] mk,
  output logic [NUM_SRC-1:0] fin,
  output logic               irq_o
);

  // A source passes only when enabled and not blocked by its mask bit.
  assign fin = src & en & ~mk;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |fin;
  end

endmodule

// File: rtl/irq_apb_regs.sv
module irq_apb_regs
  import apb_irq_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [REG_W-1:0]   pwdata,
  input  logic [NUM_SRC-1:0] fin,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] mk_q,
  output logic [REG_W-1:0]   prdata
);

  localparam int PAD_W = MAX_SRC - NUM_SRC;

  reg_sel_e           sel;
  logic               wr_acc;
  logic               rd_setup;
  logic [NUM_SRC-1:0] en_d, mk_d;
  logic [MAX_SRC-1:0] en64, mk64, st64;
  logic [REG_W-1:0]   rd_mux;

  always_comb begin
    if ((paddr >> 8) == '0) sel = decode_off(paddr[7:0]);
    else                    sel = SEL_NONE;
  end

  assign wr_acc   = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;

  // Per-bit next state; the low word feeds sources 0..31 and the high word the rest.
  always_comb begin
    en_d = en_q;
    mk_d = mk_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (wr_acc) begin
        if (i < REG_W) begin
          if (sel == SEL_EN_LO) en_d[i] = pwdata[i % REG_W];
          if (sel == SEL_MK_LO) mk_d[i] = pwdata[i % REG_W];
        end else begin
          if (sel == SEL_EN_HI) en_d[i] = pwdata[i % REG_W];
          if (sel == SEL_MK_HI) mk_d[i] = pwdata[i % REG_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      mk_q <= '0;
    end else begin
      en_q <= en_d;
      mk_q <= mk_d;
    end
  end

  // Absent positions are tied to zero in the 64-bit read views.
  generate
    if (NUM_SRC < MAX_SRC) begin : g_pad
      assign en64 = {{PAD_W{1'b0}}, en_q};
      assign mk64 = {{PAD_W{1'b0}}, mk_q};
      assign st64 = {{PAD_W{1'b0}}, fin};
    end else begin : g_full
      assign en64 = en_q;
      assign mk64 = mk_q;
      assign st64 = fin;
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_EN_LO: rd_mux = en64[REG_W-1:0];
      SEL_EN_HI: rd_mux = en64[MAX_SRC-1:REG_W];
      SEL_MK_LO: rd_mux = mk64[REG_W-1:0];
      SEL_MK_HI: rd_mux = mk64[MAX_SRC-1:REG_W];
      SEL_ST_LO: rd_mux = st64[REG_W-1:0];
      SEL_ST_HI: rd_mux = st64[MAX_SRC-1:REG_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end

endmodule

// File: rtl/apb_irq_agg.sv
module apb_irq_agg #(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] en_q, mk_q, fin;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  irq_apb_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .fin     (fin),
    .en_q    (en_q),
    .mk_q    (mk_q),
    .prdata  (prdata)
  );

  irq_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .src   (irq_src),
    .en    (en_q),
    .mk    (mk_q),
    .fin   (fin),
    .irq_o (irq_o)
  );

endmodule

// File: rtl/apb_irq_agg_chk.sv
module apb_irq_agg_chk #(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic               pready,
  input logic               pslverr,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] en_bits,
  input logic [NUM_SRC-1:0] mk_bits,
  input logic [NUM_SRC-1:0] fin_bits
);

  logic wr_acc;
  assign wr_acc = psel & penable & pwrite;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!irq_o && en_bits == '0 && mk_bits == '0));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(|fin_bits)));

  // R8
  no_wait_chk: assert property (@(posedge clk) disable iff (rst) pready && !pslverr);

  // R9
  en_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr != ADDR_W'(8'h00) && paddr != ADDR_W'(8'h04)) |=> $stable(en_bits));

  // R10
  mk_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr != ADDR_W'(8'h08) && paddr != ADDR_W'(8'h0C)) |=> $stable(mk_bits));

endmodule

bind apb_irq_agg apb_irq_agg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pready   (pready),
  .pslverr  (pslverr),
  .irq_o    (irq_o),
  .en_bits  (en_q),
  .mk_bits  (mk_q),
  .fin_bits (fin)
);

// File: tb/apb_irq_agg_tb.sv
module apb_irq_agg_tb;

  localparam int N = 40;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr, irq_o;
  logic [N-1:0]  irq_src = '0;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic [63:0] impl;
  logic [63:0] en_m, mk_m, src_m;

  always #5 clk = ~clk;

  apb_irq_agg #(.NUM_SRC(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq_src(irq_src), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d, output logic ok);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    d = prdata;
    ok = pready && !pslverr;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rd_pair(input logic [7:0] lo, output logic [63:0] v);
    logic [31:0] a, b;
    logic ok1, ok2;
    apb_rd(lo, a, ok1);
    apb_rd(lo + 8'h04, b, ok2);
    chk("R8 pready/pslverr", {62'd0, ok1, ok2}, 64'd3);
    v = {b, a};
  endtask

  task automatic set_ctl(input logic [63:0] e, input logic [63:0] m);
    apb_wr(8'h00, e[31:0]);
    apb_wr(8'h04, e[63:32]);
    apb_wr(8'h08, m[31:0]);
    apb_wr(8'h0C, m[63:32]);
    en_m = e & impl;
    mk_m = m & impl;
  endtask

  task automatic chk_status(input string req);
    logic [63:0] st, exp;
    exp = src_m & en_m & ~mk_m & impl;
    rd_pair(8'h30, st);
    chk(req, st, exp);
    chk({req, " R7 irq_o"}, {63'd0, irq_o}, {63'd0, |exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [31:0] d;
    logic ok;
    logic [63:0] pats [6];
    impl = (N >= 64) ? '1 : ((64'd1 << N) - 64'd1);
    en_m = '0; mk_m = '0; src_m = '0;

    irq_src = '1;
    src_m = impl;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1: everything clear after reset, even with all sources high
    chk("R1 prdata", {32'd0, prdata}, 64'd0);
    chk("R1 irq_o", {63'd0, irq_o}, 64'd0);
    rd_pair(8'h00, v); chk("R1 enable", v, 64'd0);
    rd_pair(8'h08, v); chk("R1 mask", v, 64'd0);
    rd_pair(8'h30, v); chk("R1 status", v, 64'd0);

    // R4: all-ones write reveals the implemented width
    set_ctl('1, '1);
    rd_pair(8'h00, v); chk("R4 R2 enable all ones", v, impl);
    rd_pair(8'h08, v); chk("R4 R3 mask all ones", v, impl);

    // R2 R3: read/write patterns
    pats[0] = 64'hA5A5_5A5A_0F0F_F0F0;
    pats[1] = 64'h0000_00FF_8000_0001;
    pats[2] = 64'h1234_5678_9ABC_DEF0;
    pats[3] = 64'hFFFF_FFFF_0000_0000;
    pats[4] = 64'h0000_0000_FFFF_FFFF;
    pats[5] = 64'h0000_0080_4000_0002;
    for (int p = 0; p < 6; p++) begin
      set_ctl(pats[p], ~pats[(p + 1) % 6]);
      rd_pair(8'h00, v); chk("R2 enable pattern", v, en_m);
      rd_pair(8'h08, v); chk("R3 mask pattern", v, mk_m);
    end

    // R5: walking source with everything enabled, nothing masked
    set_ctl('1, '0);
    for (int i = 0; i < 64; i++) begin
      src_m = (64'd1 << i) & impl;
      @(negedge clk) irq_src = src_m[N-1:0];
      chk_status("R5 walking source");
    end

    // R5: walking unmasked bit with all sources high
    src_m = impl;
    @(negedge clk) irq_src = src_m[N-1:0];
    for (int i = 0; i < 64; i++) begin
      set_ctl('1, ~(64'd1 << i));
      chk_status("R5 walking unmask");
    end

    // R5: mixed patterns
    for (int p = 0; p < 6; p++) begin
      src_m = pats[(p + 2) % 6] & impl;
      @(negedge clk) irq_src = src_m[N-1:0];
      set_ctl(pats[p], pats[(p + 4) % 6]);
      chk_status("R5 mixed");
    end

    // R6: level following, no latching, read does not clear
    set_ctl('1, '0);
    src_m = 64'h0000_0001_0000_0100 & impl;
    @(negedge clk) irq_src = src_m[N-1:0];
    chk_status("R6 first read");
    chk_status("R6 second read");
    src_m = '0;
    @(negedge clk) irq_src = '0;
    chk_status("R6 after drop");

    // R7: one edge of latency on irq_o
    @(negedge clk) irq_src = '0;
    @(negedge clk);
    irq_src[3] = 1'b1;
    #1 chk("R7 irq_o before edge", {63'd0, irq_o}, 64'd0);
    @(negedge clk) chk("R7 irq_o after edge", {63'd0, irq_o}, 64'd1);
    irq_src[3] = 1'b0;
    #1 chk("R7 irq_o hold", {63'd0, irq_o}, 64'd1);
    @(negedge clk) chk("R7 irq_o drop", {63'd0, irq_o}, 64'd0);

    // R9: unmapped offsets
    set_ctl(64'h0000_0055_0000_AAAA, 64'h0000_0011_0000_2222);
    apb_wr(8'h10, '1); apb_wr(8'h2C, '1); apb_wr(8'h38, '1); apb_wr(8'hFC, '1);
    apb_rd(8'h10, d, ok); chk("R9 unmapped read 0x10", {32'd0, d}, 64'd0);
    apb_rd(8'h38, d, ok); chk("R9 unmapped read 0x38", {32'd0, d}, 64'd0);
    apb_rd(8'hFC, d, ok); chk("R9 unmapped read 0xFC", {32'd0, d}, 64'd0);
    rd_pair(8'h00, v); chk("R9 enable unchanged", v, en_m);
    rd_pair(8'h08, v); chk("R9 mask unchanged", v, mk_m);

    // R10: status offsets ignore writes
    src_m = 64'h0000_00FF_0000_0F0F & impl;
    @(negedge clk) irq_src = src_m[N-1:0];
    apb_wr(8'h30, '1); apb_wr(8'h34, '1);
    rd_pair(8'h00, v); chk("R10 enable unchanged", v, en_m);
    rd_pair(8'h08, v); chk("R10 mask unchanged", v, mk_m);
    chk_status("R10 status unchanged");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule